// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block moves data words between a parallel valid/ready interface and a serial line clocked by a bit clock and framed by a frame sync. One control register sets the serial format at run time: bit order, word length (3 to 32 bits), 16-to-32-bit packing, whether the bit clock comes from an internal divider or from the clock pin, standard framing or stereo sample-pair framing, and which clock edge samples. A second register holds the 16-bit divisor for the internal bit clock.

The clock, frame sync and serial data pins are first brought into the system clock domain, and the bit clock is detected by its edges. In standard framing a word begins after the frame sync is sampled high. In stereo framing a word begins after the frame sync is sampled at a new level. The bit clock can be generated inside the block. In that case the block is the frame master: it drives the bit clock and the frame sync, and each frame is one frame-sync slot followed by the data bits.

Top module: `sync_serial_port`

## Requirements
- R1: Control bit 3 set sends and receives the least significant bit first; clear sends the most significant bit first. In stereo mode the most significant bit always goes first and bit 3 is ignored.
- R2: Control bits 8:4 hold the word length minus one. A received word is the last word-length bits.
- R3: A control write (address 0) is rejected if its length code is 0 or 1, if it selects stereo mode with a length code below 7, or if it enables packing with a length code other than 15. A rejected write leaves the control register unchanged and raises cfg_err_o for exactly one cycle. A legal write keeps cfg_err_o low.
- R4: With control bit 9 set, two 16-bit serial words form one 32-bit parallel word. The first word received fills bits 15:0. On transmit, bits 15:0 go out first and bits 31:16 follow in the next frame.
- R5: With control bit 10 set, sck_o toggles every divisor system cycles and sck_oe_o is high. The divisor is the low 16 bits written at address 1, and 0 acts as 1. With bit 10 clear, sck_oe_o is low, sck_o stays low and sck_i is used.
- R6: Control bit 11 selects stereo mode. A word starts after the sampled frame sync changes level. As master, fs_o toggles once per word and holds its level between toggles.
- R7: Control bit 12 set samples serial data and frame sync on rising bit-clock edges; clear samples them on falling edges.
- R8: Transmit data and generated frame sync change on the bit-clock edge opposite the sampling edge. In standard master mode fs_o is high for exactly one bit clock, in the slot before the first data bit. A frame lasts word length plus one bit clocks.
- R9: A received word narrower than 32 bits is right-justified and zero-filled. rx_valid_o and rx_data_o hold until rx_ready_i is high. A newer word overwrites an unread one.
- R10: tx_ready_o is low while a transmit word waits. A frame that starts with no word waiting sends all zeros.
- R11: After reset: tx_ready_o high, rx_valid_o, sd_o, fs_o, sck_oe_o and cfg_err_o low, 8-bit words, MSB first, external clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 1 | 0 control, 1 divisor |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_err_o | output | 1 | One-cycle pulse on a rejected control write |
| tx_data_i | input | 32 | Transmit word |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_ready_o | output | 1 | Transmit holding register free |
| rx_data_o | output | 32 | Received word |
| rx_valid_o | output | 1 | Received word valid |
| rx_ready_i | input | 1 | Received word taken |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| fs_i | input | 1 | Frame sync in (external clock mode) |
| fs_o | output | 1 | Frame sync out (internal clock mode) |
| sck_i | input | 1 | Bit clock in |
| sck_o | output | 1 | Bit clock out |
| sck_oe_o | output | 1 | Bit clock output enable |

## Verification
The bench drives slave frames at the 3-bit and 32-bit length limits, in both bit orders and on both sampling edges. It also runs stereo frames with bit 3 set, where a design that honoured bit 3 would reverse the word. Illegal length, stereo and packing codes are written, followed by a frame at the old format; a design that accepted any of them would send and capture the wrong number of bits. The packing run checks half order and that nothing is delivered after the first half. The bench also checks an unread word that is later overwritten and a frame with no transmit word, where stale data would be sent. In a master loopback it measures the bit clock half period, the width and period of the frame sync pulse, and the stereo frame sync interval.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned LEN_W = 5;

  typedef struct packed {
    logic             rise;
    logic             stereo;
    logic             iclk;
    logic             pack;
    logic [LEN_W-1:0] slen;
    logic             lsbf;
  } ssp_cfg_t;

  localparam ssp_cfg_t CFG_RST = '{rise: 1'b0, stereo: 1'b0, iclk: 1'b0,
                                   pack: 1'b0, slen: 5'd7, lsbf: 1'b0};

  function automatic ssp_cfg_t ctrl_decode(input logic [REG_W-1:0] w);
    return '{rise: w[12], stereo: w[11], iclk: w[10], pack: w[9],
             slen: w[8:4], lsbf: w[3]};
  endfunction

  function automatic logic ctrl_legal(input ssp_cfg_t c);
    return (c.slen >= 5'd2) && !(c.stereo && c.slen < 5'd7) &&
           !(c.pack && c.slen != 5'd15);
  endfunction
endpackage

// File: rtl/ssp_cfg_regs.sv
module ssp_cfg_regs
  import ssp_pkg::*;
#(
  parameter int unsigned      DIV_W   = 16,
  parameter logic [DIV_W-1:0] DIV_RST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output ssp_cfg_t         cfg_o,
  output logic [DIV_W-1:0] div_o,
  output logic             err_o
);
  ssp_cfg_t         cfg_q;
  logic [DIV_W-1:0] div_q;
  logic             err_q;
  ssp_cfg_t         cfg_new;
  logic             unused_wdata;

  assign cfg_new      = ctrl_decode(wdata_i);
  assign unused_wdata = ^{wdata_i[REG_W-1:13], wdata_i[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      div_q <= DIV_RST;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (we_i && !addr_i) begin
        if (ctrl_legal(cfg_new)) cfg_q <= cfg_new;
        else                     err_q <= 1'b1;
      end else if (we_i) begin
        div_q <= wdata_i[DIV_W-1:0];
      end
    end
  end

  assign cfg_o = cfg_q;
  assign div_o = div_q;
  assign err_o = err_q;

  a_r3_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i && !ctrl_legal(cfg_new)) |=> (err_o && $stable(cfg_q)));
  a_r3_legal_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i && ctrl_legal(cfg_new)) |=> !err_o);
  a_r2_len_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.slen >= 5'd2);
endmodule

// File: rtl/ssp_bitclk.sv
module ssp_bitclk #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned SYNC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iclk_i,
  input  logic             rise_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             sck_i,
  input  logic             sd_i,
  input  logic             fs_i,
  output logic             sck_o,
  output logic             samp_o,
  output logic             drv_o,
  output logic             sd_s_o,
  output logic             fs_s_o
);
  logic [SYNC-1:0]  sck_sy, sd_sy, fs_sy;
  logic [DIV_W-1:0] cnt_q, div_eff;
  logic             sck_q, lvl, lvl_q, up_e, dn_e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sy <= '0;
      sd_sy  <= '0;
      fs_sy  <= '0;
    end else begin
      sck_sy <= {sck_sy[SYNC-2:0], sck_i};
      sd_sy  <= {sd_sy[SYNC-2:0], sd_i};
      fs_sy  <= {fs_sy[SYNC-2:0], fs_i};
    end
  end

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!iclk_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (cnt_q >= div_eff - DIV_W'(1)) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign lvl = iclk_i ? sck_q : sck_sy[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl;
  end

  assign up_e   = lvl & ~lvl_q;
  assign dn_e   = ~lvl & lvl_q;
  assign samp_o = rise_i ? up_e : dn_e;
  assign drv_o  = rise_i ? dn_e : up_e;
  assign sck_o  = sck_q;
  assign sd_s_o = sd_sy[SYNC-1];
  assign fs_s_o = fs_sy[SYNC-1];

  a_r5_ext_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iclk_i |=> !sck_o);
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int unsigned DW = 32,
  localparam int unsigned IW = $clog2(DW) + 1,
  localparam int unsigned PW = $clog2(DW),
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] wlen_i,
  input  logic          lsbf_i,
  input  logic          pack_i,
  input  logic          start_i,
  input  logic          drv_i,
  input  logic [DW-1:0] data_i,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          sd_o
);
  logic [DW-1:0] hold_q, sh_q;
  logic          full_q, arm_q, on_q, half_q;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      arm_q  <= 1'b0;
      on_q   <= 1'b0;
      half_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (drv_i) begin
        if (arm_q) begin
          arm_q <= 1'b0;
          on_q  <= 1'b1;
          idx_q <= '0;
          if (pack_i && half_q) begin
            sh_q   <= sh_q >> HW;
            half_q <= 1'b0;
          end else if (full_q) begin
            sh_q   <= hold_q;
            full_q <= 1'b0;
            half_q <= pack_i;
          end else begin
            sh_q   <= '0;   // underrun sends zeros
            half_q <= 1'b0;
          end
        end else if (on_q) begin
          if (idx_q == wlen_i - IW'(1)) on_q <= 1'b0;
          idx_q <= idx_q + IW'(1);
        end
      end
      if (start_i) arm_q <= 1'b1;
      if (valid_i && ready_o) begin
        hold_q <= data_i;
        full_q <= 1'b1;
      end
    end
  end

  assign ready_o = ~full_q;
  assign pos     = lsbf_i ? idx_q[PW-1:0] : PW'(wlen_i - IW'(1) - idx_q);
  assign sd_o    = on_q & sh_q[pos];

  a_r10_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !drv_i) |=> full_q);
  a_r10_underrun_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_i && arm_q && !full_q && !(pack_i && half_q)) |=> !sd_o);
  a_r8_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_q |-> (idx_q < wlen_i));
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int unsigned DW = 32,
  localparam int unsigned IW = $clog2(DW) + 1,
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] wlen_i,
  input  logic          lsbf_i,
  input  logic          pack_i,
  input  logic          start_i,
  input  logic          samp_i,
  input  logic          sd_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  input  logic          ready_i
);
  logic [DW-1:0] acc_q, nacc, data_q;
  logic [HW-1:0] low_q;
  logic [IW-1:0] idx_q;
  logic          on_q, half_q, valid_q, last, fin;

  assign nacc = lsbf_i ? (acc_q | (DW'(sd_i) << idx_q)) : {acc_q[DW-2:0], sd_i};
  assign last = !start_i && samp_i && on_q && (idx_q == wlen_i - IW'(1));
  assign fin  = last && !(pack_i && !half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      data_q  <= '0;
      low_q   <= '0;
      idx_q   <= '0;
      on_q    <= 1'b0;
      half_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (valid_q && ready_i) valid_q <= 1'b0;
      if (start_i) begin
        on_q  <= 1'b1;
        idx_q <= '0;
        acc_q <= '0;
      end else if (samp_i && on_q) begin
        if (last) begin
          on_q <= 1'b0;
          if (pack_i && !half_q) begin
            low_q  <= nacc[HW-1:0];
            half_q <= 1'b1;
          end else begin
            data_q  <= pack_i ? {nacc[HW-1:0], low_q} : nacc;
            valid_q <= 1'b1;
            half_q  <= 1'b0;
          end
        end else begin
          acc_q <= nacc;
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i && !fin) |=> (valid_q && $stable(data_q)));
  a_r9_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !pack_i) |=> ((wlen_i == IW'(DW)) || ((data_q >> wlen_i) == '0)));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DIV_W = 16,
  parameter int unsigned SYNC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_addr_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic          cfg_err_o,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_ready_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  input  logic          rx_ready_i,
  input  logic          sd_i,
  output logic          sd_o,
  input  logic          fs_i,
  output logic          fs_o,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe_o
);
  localparam int unsigned IW = $clog2(DW) + 1;

  ssp_cfg_t         cfg;
  logic [DIV_W-1:0] div;
  logic             samp, drv, sd_s, fs_s, fs_int, fsp_q, fs_q, start, lsbf_eff;
  logic [IW-1:0]    wlen, slot_q, slot_nxt;

  ssp_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .div_o(div), .err_o(cfg_err_o)
  );

  ssp_bitclk #(.DIV_W(DIV_W), .SYNC(SYNC)) u_clk (
    .clk_i, .rst_ni, .iclk_i(cfg.iclk), .rise_i(cfg.rise), .div_i(div),
    .sck_i, .sd_i, .fs_i, .sck_o, .samp_o(samp), .drv_o(drv),
    .sd_s_o(sd_s), .fs_s_o(fs_s)
  );

  assign wlen     = IW'(cfg.slen) + IW'(1);
  assign lsbf_eff = cfg.lsbf & ~cfg.stereo;
  assign slot_nxt = (slot_q >= wlen) ? '0 : slot_q + IW'(1);

  // Frame master: slot 0 carries the frame sync, slots 1..wlen the data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '1;
      fs_q   <= 1'b0;
    end else if (!cfg.iclk) begin
      slot_q <= wlen;
      fs_q   <= 1'b0;
    end else if (drv) begin
      slot_q <= slot_nxt;
      if (cfg.stereo) fs_q <= fs_q ^ (slot_nxt == '0);
      else            fs_q <= (slot_nxt == '0);
    end
  end

  assign fs_int = cfg.iclk ? fs_q : fs_s;
  assign start  = samp && (cfg.stereo ? (fs_int ^ fsp_q) : fs_int);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fsp_q <= 1'b0;
    else if (samp) fsp_q <= fs_int;
  end

  ssp_tx #(.DW(DW)) u_tx (
    .clk_i, .rst_ni, .wlen_i(wlen), .lsbf_i(lsbf_eff), .pack_i(cfg.pack),
    .start_i(start), .drv_i(drv), .data_i(tx_data_i), .valid_i(tx_valid_i),
    .ready_o(tx_ready_o), .sd_o
  );

  ssp_rx #(.DW(DW)) u_rx (
    .clk_i, .rst_ni, .wlen_i(wlen), .lsbf_i(lsbf_eff), .pack_i(cfg.pack),
    .start_i(start), .samp_i(samp), .sd_i(sd_s), .data_o(rx_data_o),
    .valid_o(rx_valid_o), .ready_i(rx_ready_i)
  );

  assign fs_o     = fs_q;
  assign sck_oe_o = cfg.iclk;

  a_r8_fs_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.iclk && !cfg.stereo && fs_o && drv) |=> !fs_o);
  a_r6_ws_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.iclk && cfg.stereo && !drv) |=> $stable(fs_o));
endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb_top;
  localparam int H = 8;  // bench bit-clock half period in system cycles

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_addr_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic        cfg_err_o;
  logic [31:0] tx_data_i = '0, rx_data_o;
  logic        tx_valid_i = 1'b0, tx_ready_o, rx_valid_o, rx_ready_i = 1'b0;
  logic        sd_i, sd_o, fs_i = 1'b0, fs_o, sck_i = 1'b0, sck_o, sck_oe_o;
  logic        sd_drv = 1'b0, loop_en = 1'b0, fs_lvl = 1'b0, done = 1'b0;
  int          errs = 0, chks = 0;

  assign sd_i = loop_en ? sd_o : sd_drv;
  always #2 clk = ~clk;

  sync_serial_port dut_i (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_err_o,
    .tx_data_i, .tx_valid_i, .tx_ready_o, .rx_data_o, .rx_valid_o, .rx_ready_i,
    .sd_i, .sd_o, .fs_i, .fs_o, .sck_i, .sck_o, .sck_oe_o
  );

  // ctrl: [12] rise, [11] stereo, [10] iclk, [9] pack, [8:4] len-1, [3] lsb first
  localparam logic [31:0] VC [7] = '{32'h0070, 32'h0078, 32'h1020, 32'h11F8,
                                     32'h08F8, 32'h1970, 32'h00C0};
  localparam logic [31:0] VT [7] = '{32'h0000_00A6, 32'h0000_0035, 32'h0000_0005,
                                     32'h8123_4567, 32'h1234_C3A1, 32'h00AB_CDEF,
                                     32'h0000_1A5B};
  localparam logic [31:0] VR [7] = '{32'h0000_005C, 32'h0000_00C1, 32'h0000_0006,
                                     32'hF00D_BEEF, 32'h0000_7E81, 32'h00F0_0F5A,
                                     32'h0000_1234};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    tx_valid_i = 1'b1; tx_data_i = d;
    @(negedge clk);
    tx_valid_i = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    rx_ready_i = 1'b1;
    @(negedge clk);
    rx_ready_i = 1'b0;
  endtask

  task automatic slot(input bit rise, input bit fsv, input bit sdv, output bit sdo);
    sck_i = ~rise; fs_i = fsv; sd_drv = sdv;
    repeat (H) @(negedge clk);
    sdo = sd_o;
    sck_i = rise;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame(input int len, input bit lsb, input bit st, input bit rise,
                       input logic [31:0] rxw, output logic [31:0] txo);
    bit b;
    txo = '0;
    if (st) fs_lvl = ~fs_lvl;
    slot(rise, st ? fs_lvl : 1'b1, 1'b0, b);
    for (int i = 0; i < len; i++) begin
      automatic int p = lsb ? i : len - 1 - i;
      slot(rise, st ? fs_lvl : 1'b0, rxw[p], b);
      txo[p] = b;
    end
    slot(rise, st ? fs_lvl : 1'b0, 1'b0, b);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    logic [31:0] txo, msk, c;
    int len, n;
    bit lsb, st, rise;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(tx_ready_o && !rx_valid_o && !sd_o && !fs_o && !sck_oe_o && !cfg_err_o,
        "R11 reset outputs", {26'b0, tx_ready_o, rx_valid_o, sd_o, fs_o, sck_oe_o, cfg_err_o},
        32'h20);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table: slave frames across lengths, orders, edges and modes
    for (int v = 0; v < 7; v++) begin
      c    = VC[v];
      len  = int'(c[8:4]) + 1;
      st   = c[11];
      lsb  = c[3] & ~st;
      rise = c[12];
      msk  = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
      wr(1'b0, c);
      chk(!cfg_err_o, "R3 legal write no error", {31'b0, cfg_err_o}, 32'h0);
      sck_i = rise;
      repeat (6) @(negedge clk);
      push(VT[v]);
      chk(!tx_ready_o, "R10 ready low while word waits", {31'b0, tx_ready_o}, 32'h0);
      frame(len, lsb, st, rise, VR[v], txo);
      chk(rx_valid_o && rx_data_o == VR[v], "R1 R2 R6 R7 R9 rx word",
          rx_data_o, VR[v]);
      chk(txo == (VT[v] & msk), "R1 R2 R6 R7 R8 tx serial word", txo, VT[v] & msk);
      ack();
      chk(!rx_valid_o, "R9 valid clears on ready", {31'b0, rx_valid_o}, 32'h0);
    end

    // R3 rejected writes; config stays 13-bit MSB first falling edge
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 1'b0; cfg_wdata_i = 32'h0010;
    @(negedge clk);
    cfg_we_i = 1'b0;
    chk(cfg_err_o, "R3 length code 1 flagged", {31'b0, cfg_err_o}, 32'h1);
    @(negedge clk);
    chk(!cfg_err_o, "R3 error is one cycle", {31'b0, cfg_err_o}, 32'h0);
    wr(1'b0, 32'h0000);
    chk(cfg_err_o, "R3 length code 0 flagged", {31'b0, cfg_err_o}, 32'h1);
    wr(1'b0, 32'h0850);
    chk(cfg_err_o, "R3 short stereo flagged", {31'b0, cfg_err_o}, 32'h1);
    wr(1'b0, 32'h0270);
    chk(cfg_err_o, "R3 pack without 16 flagged", {31'b0, cfg_err_o}, 32'h1);
    push(32'h0000_0B3D);
    frame(13, 1'b0, 1'b0, 1'b0, 32'h0000_15A7, txo);
    chk(rx_valid_o && rx_data_o == 32'h15A7, "R3 old format kept rx", rx_data_o, 32'h15A7);
    chk(txo == 32'h0B3D, "R3 old format kept tx", txo, 32'h0B3D);
    ack();

    // R4 packing
    wr(1'b0, 32'h02F0);
    sck_i = 1'b0;
    push(32'hA5A5_1234);
    frame(16, 1'b0, 1'b0, 1'b0, 32'h1111, txo);
    chk(!rx_valid_o, "R4 no output after first half", {31'b0, rx_valid_o}, 32'h0);
    chk(txo == 32'h1234, "R4 low half sent first", txo, 32'h1234);
    frame(16, 1'b0, 1'b0, 1'b0, 32'h2222, txo);
    chk(rx_valid_o && rx_data_o == 32'h2222_1111, "R4 packed rx order", rx_data_o,
        32'h2222_1111);
    chk(txo == 32'hA5A5, "R4 high half sent second", txo, 32'hA5A5);
    ack();

    // R9 hold and overwrite; R10 underrun
    wr(1'b0, 32'h0070);
    frame(8, 1'b0, 1'b0, 1'b0, 32'h11, txo);
    chk(txo == 32'h0, "R10 underrun sends zeros", txo, 32'h0);
    repeat (30) @(negedge clk);
    chk(rx_valid_o && rx_data_o == 32'h11, "R9 unread word held", rx_data_o, 32'h11);
    frame(8, 1'b0, 1'b0, 1'b0, 32'h22, txo);
    chk(rx_valid_o && rx_data_o == 32'h22, "R9 newer word overwrites", rx_data_o, 32'h22);
    ack();

    // R5 R8 master loopback, divisor 4, 8-bit, rising sample edge
    loop_en = 1'b1;
    wr(1'b1, 32'h0004);
    push(32'h0000_00C9);
    wr(1'b0, 32'h1470);
    chk(sck_oe_o, "R5 clock output enabled", {31'b0, sck_oe_o}, 32'h1);
    for (int k = 0; k < 3000 && !rx_valid_o; k++) @(negedge clk);
    chk(rx_valid_o && rx_data_o == 32'hC9, "R8 master loopback word", rx_data_o, 32'hC9);
    ack();
    begin
      logic s0;
      s0 = sck_o;
      for (int k = 0; k < 100 && sck_o == s0; k++) @(negedge clk);
      s0 = sck_o; n = 0;
      for (int k = 0; k < 100 && sck_o == s0; k++) begin @(negedge clk); n++; end
    end
    chk(n == 4, "R5 half period equals divisor", n, 4);
    for (int k = 0; k < 500 && fs_o; k++) @(negedge clk);
    for (int k = 0; k < 500 && !fs_o; k++) @(negedge clk);
    n = 0;
    for (int k = 0; k < 500 && fs_o; k++) begin @(negedge clk); n++; end
    chk(n == 8, "R8 frame sync one bit clock wide", n, 8);
    for (int k = 0; k < 500 && !fs_o; k++) begin @(negedge clk); n++; end
    chk(n == 72, "R8 frame period word length plus one", n, 72);

    // R6 stereo master: fs toggles once per frame
    wr(1'b0, 32'h1C70);
    repeat (200) @(negedge clk);
    begin
      logic f0;
      f0 = fs_o;
      for (int k = 0; k < 500 && fs_o == f0; k++) @(negedge clk);
      f0 = fs_o; n = 0;
      for (int k = 0; k < 500 && fs_o == f0; k++) begin @(negedge clk); n++; end
    end
    chk(n == 72, "R6 stereo frame sync level per word", n, 72);
    wr(1'b0, 32'h0070);
    repeat (2) @(negedge clk);
    chk(!sck_oe_o && !sck_o, "R5 external mode releases clock",
        {30'b0, sck_oe_o, sck_o}, 32'h0);
    loop_en = 1'b0;
    ack();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule